// File: doc/BRIEF.md
# Sampling Clock Slowness Detector

This block watches a free-running sampling clock that has no phase or frequency relation to the bus clock. It decides, in the bus clock domain, whether that clock has become too slow. The sampling clock flips a toggle flop. The toggle is carried into the bus domain through a synchronizer, and there a gap counter measures how many bus cycles pass between rising edges of the synchronized toggle. One toggle period spans two sampling periods. At the nominal limit of one sampling cycle per 32 bus cycles, that period is therefore 64 bus cycles. A longer gap raises a live error status.

The live status is a level that follows the clock condition and drops by itself once the sampling clock is fast enough again. A separate sticky flag captures the moment the status rises and holds until software writes it to zero. Detection can be switched off with a disable bit. That bit can only be changed while the generator enable is low. The counter and status stay in reset while the generator is disabled.

Top module: `smp_clk_monitor`

## Requirements
- R1: After reset, `err_live_o`, `err_flag_o` and `det_dis_o` are all 0.
- R2: While enabled with detection on, `err_live_o` never rises if rising edges of the sampling clock come at least once every 32 bus cycles.
- R3: While enabled with detection on, a sampling clock slower than one rising edge per 80 bus cycles, or a stopped one, drives `err_live_o` to 1.
- R4: With the sampling clock stopped, `err_live_o` first reads 1 after the 65th rising bus clock edge that samples `en_i` high, that is, once the gap counter exceeds 64 (twice the ratio).
- R5: `err_live_o` returns to 0 without software action once the sampling clock is back in range.
- R6: While `det_dis_o` is 1, `err_live_o` stays 0 and `err_flag_o` is not set, even with the sampling clock stopped.
- R7: A write through `dis_wr_i`/`dis_wdata_i` updates the disable bit (seen on `det_dis_o`) only when `en_i` is 0. A write while `en_i` is 1 is ignored.
- R8: When `en_i` is 0, `err_live_o` reads 0 after the next bus clock edge, and the gap counter restarts from zero.
- R9: `err_flag_o` goes to 1 on the bus cycle after `err_live_o` rises. It stays 1 after `err_live_o` falls and while `en_i` is 0.
- R10: A one-cycle pulse on `flag_clr_i` (a software write of zero) clears `err_flag_o`. If the pulse coincides with a new rise of the live status, the set wins.
- R11: After a clear, `err_flag_o` stays 0 while `err_live_o` stays high, because the flag is set only at a rising edge of the live status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| smp_clk_i | input | 1 | Undivided sampling clock, asynchronous to clk_i |
| en_i | input | 1 | Generator enable |
| dis_wr_i | input | 1 | Write strobe for the detection-disable bit |
| dis_wdata_i | input | 1 | Value written to the detection-disable bit |
| flag_clr_i | input | 1 | Software write-zero pulse for the sticky flag |
| det_dis_o | output | 1 | Current detection-disable bit |
| err_live_o | output | 1 | Live clock-too-slow status |
| err_flag_o | output | 1 | Sticky clock error flag |

## Verification
The table drives the sampling clock at 10 ns and 200 ns periods and at a 300 ns period that sits just inside the 64-cycle gap. It also drives an 800 ns period and a stopped clock. This separates a gap counter that measures the full toggle period from one with the wrong limit or one that counts single edges. Directed runs start with the clock stopped and count bus edges to the exact rise of the live status. They then check that the live status and the sticky flag separate when the clock returns and when software clears the flag while the error persists. Further runs drive disable-bit writes with the enable high and with it low, and a clear that coincides with a new error.

// File: rtl/smp_mon_pkg.sv
package smp_mon_pkg;
  localparam int unsigned RATIO_DEF  = 32;
  localparam int unsigned SYNC_DEF   = 2;

  function automatic int unsigned gap_limit(int unsigned ratio);
    return 2 * ratio;
  endfunction

  function automatic int unsigned gap_cnt_w(int unsigned ratio);
    return $clog2(2 * ratio + 2);
  endfunction
endpackage

// File: rtl/smp_toggle_gen.sv
module smp_toggle_gen (
  input  logic smp_clk_i,
  input  logic rst_ni,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge smp_clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/smp_edge_sync.sv
module smp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/smp_gap_timer.sv
module smp_gap_timer #(
  parameter int unsigned LIMIT = 64,
  parameter int unsigned CNT_W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic rise_i,
  output logic live_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic             live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else if (!active_i) begin
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else begin
      live_q <= !rise_i && (cnt_q >= CNT_LIM);
      if (rise_i)                cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign live_o = live_q;

  // R8
  inactive_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !live_o);
  // R5
  edge_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> !live_o);
  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/smp_clk_monitor.sv
module smp_clk_monitor
  import smp_mon_pkg::*;
#(
  parameter int unsigned RATIO       = RATIO_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_clk_i,
  input  logic en_i,
  input  logic dis_wr_i,
  input  logic dis_wdata_i,
  input  logic flag_clr_i,
  output logic det_dis_o,
  output logic err_live_o,
  output logic err_flag_o
);
  localparam int unsigned LIMIT = gap_limit(RATIO);
  localparam int unsigned CNT_W = gap_cnt_w(RATIO);

  logic tog;
  logic tog_rise;
  logic active;
  logic live;
  logic live_prev_q;
  logic live_rise;
  logic dis_q;
  logic flag_q;

  smp_toggle_gen u_tog (
    .smp_clk_i (smp_clk_i),
    .rst_ni    (rst_ni),
    .tog_o     (tog)
  );

  smp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (tog),
    .rise_o  (tog_rise)
  );

  // disable bit only changes while the generator is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 dis_q <= 1'b0;
    else if (dis_wr_i && !en_i)  dis_q <= dis_wdata_i;
  end

  assign active = en_i & ~dis_q;

  smp_gap_timer #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .rise_i   (tog_rise),
    .live_o   (live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_prev_q <= 1'b0;
    else         live_prev_q <= live;
  end

  assign live_rise = live & ~live_prev_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (live_rise)  flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign det_dis_o  = dis_q;
  assign err_live_o = live;
  assign err_flag_o = flag_q;

  // R9
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_rise |=> err_flag_o);
  // R11
  flag_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_flag_o) |-> $past(live_rise));
  // R7
  dis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(det_dis_o));
  // R6
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_dis_o |-> !err_live_o);
  // R10
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !live_rise) |=> !err_flag_o);
endmodule

// File: tb/smp_clk_monitor_tb.sv
`timescale 1ns/1ps
module smp_clk_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 5;
  localparam int HALF_NS [ROWS] = '{5, 100, 150, 400, 0};
  localparam bit EXP_ERR [ROWS] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic smp_clk = 1'b0;
  logic en = 1'b0, dis_wr = 1'b0, dis_wdata = 1'b0, flag_clr = 1'b0;
  logic det_dis, err_live, err_flag;
  int   smp_half = 5;
  int   n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always begin
    if (smp_half == 0) #10;
    else begin
      #(smp_half);
      smp_clk = ~smp_clk;
    end
  end

  smp_clk_monitor u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .smp_clk_i   (smp_clk),
    .en_i        (en),
    .dis_wr_i    (dis_wr),
    .dis_wdata_i (dis_wdata),
    .flag_clr_i  (flag_clr),
    .det_dis_o   (det_dis),
    .err_live_o  (err_live),
    .err_flag_o  (err_flag)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr_pulse();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    #1;
  endtask

  task automatic dis_write(logic v);
    @(negedge clk); dis_wr = 1'b1; dis_wdata = v;
    @(negedge clk); dis_wr = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int hits;
    int n;
    // R1 reset state
    #(CLK_PERIOD * 3 + 2);
    chk("R1 live", err_live, 0);
    chk("R1 flag", err_flag, 0);
    chk("R1 dis", det_dis, 0);
    @(negedge clk); rst_ni = 1'b1;
    cyc(2);
    chk("R1 live after release", err_live, 0);
    @(negedge clk); en = 1'b1;

    // R2/R3 table walk
    for (int r = 0; r < ROWS; r++) begin
      smp_half = HALF_NS[r];
      cyc(300);
      hits = 0;
      for (int k = 0; k < 600; k++) begin
        @(posedge clk); #1;
        if (err_live) hits++;
      end
      if (EXP_ERR[r]) chk($sformatf("R3 row%0d live seen", r), hits > 0, 1);
      else            chk($sformatf("R2 row%0d live seen", r), hits > 0, 0);
    end

    // R9 sticky after live clears; R5 self-clear
    chk("R9 flag set", err_flag, 1);
    smp_half = 5;
    cyc(20);
    chk("R5 live cleared", err_live, 0);
    chk("R9 flag kept", err_flag, 1);
    @(negedge clk); en = 1'b0;
    cyc(3);
    chk("R9 flag kept while disabled", err_flag, 1);
    @(negedge clk); en = 1'b1;
    clr_pulse();
    chk("R10 flag cleared", err_flag, 0);

    // R11 clear while error persists, R8 prompt drop
    smp_half = 0;
    cyc(200);
    chk("R3 stopped live", err_live, 1);
    chk("R9 flag re-set", err_flag, 1);
    clr_pulse();
    cyc(50);
    chk("R11 flag stays clear", err_flag, 0);
    chk("R11 live still high", err_live, 1);
    @(negedge clk); en = 1'b0;
    cyc(1);
    chk("R8 live drops", err_live, 0);
    cyc(5);

    // R4 exact threshold from enable
    @(negedge clk); en = 1'b1;
    n = 0;
    for (int k = 1; k <= 200; k++) begin
      @(posedge clk); #1;
      if (err_live) begin n = k; break; end
    end
    chk("R4 edges to live", n, 65);
    cyc(1);
    chk("R9 flag one cycle later", err_flag, 1);

    // R10 set wins over coincident clear
    @(negedge clk); en = 1'b0;
    clr_pulse();
    chk("R10 flag cleared again", err_flag, 0);
    @(negedge clk); en = 1'b1;
    repeat (65) @(posedge clk);
    #1; flag_clr = 1'b1;
    @(posedge clk); #1; flag_clr = 1'b0;
    chk("R10 set wins", err_flag, 1);
    clr_pulse();
    chk("R10 clear after", err_flag, 0);

    // R7 / R6 disable bit
    dis_write(1'b1);
    chk("R7 write while enabled ignored", det_dis, 0);
    @(negedge clk); en = 1'b0;
    dis_write(1'b1);
    chk("R7 write while disabled", det_dis, 1);
    @(negedge clk); en = 1'b1;
    cyc(200);
    chk("R6 live held low", err_live, 0);
    chk("R6 flag not set", err_flag, 0);
    dis_write(1'b0);
    chk("R7 clear while enabled ignored", det_dis, 1);
    @(negedge clk); en = 1'b0;
    dis_write(1'b0);
    chk("R7 clear while disabled", det_dis, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule